// File: doc/BRIEF.md
# Interleaving Transaction Splitter

This block sits at the request side of an initiator network interface. It takes one bus read or write transaction at a time, given as a start address and a beat count. It cuts the transaction into one packet request per interleave block. The channel of each piece is decoded from the address of that piece, so consecutive blocks fall on different channel controllers. A transaction that fits inside one block leaves as one packet.

Before a packet is queued, the block reserves room for its response in a reorder buffer. It does this by drawing down a credit counter, which the reorder buffer replenishes one credit per delivered response beat. A transaction whose total response would exceed the whole reorder buffer holds its first piece back until every credit has come home. Each packet carries the next value of a consecutive sequence counter. The packet goes to a high or a low priority queue, chosen by a mask indexed with the source ID.

Addresses count beats. With default parameters, a block holds 4 beats, there are 4 channels, and the reorder buffer has 24 beat entries.

Top module: `ilv_splitter`

## Requirements
- R1: After reset both queue outputs are empty (`hi_valid` and `lo_valid` low), `req_ready` is high and all 24 credits are free.
- R2: The channel field of a packet equals bits [3:2] of that piece's start address, i.e. (address / 4) mod 4.
- R3: A transaction of `req_len`+1 beats is cut at every address that is a multiple of 4. Pieces are issued in address order, and an unaligned start gives a shorter first piece. Each packet carries its start address in bits [15:0] and its beat count minus one in bits [17:16].
- R4: A transaction that lies inside one aligned 4-beat block produces exactly one packet.
- R5: Bits [27:20] of each packet hold a sequence number that starts at 0 after reset and rises by one per issued packet across both queues, wrapping modulo 256.
- R6: Reserved response beats never exceed 24. Reserved beats are those issued in packets and not yet returned through `cred_ret`. When the free credits are fewer than the next piece's beats, issue stalls until credits return.
- R7: For a transaction of more than 24 beats, the first packet is issued only when all 24 credits are free. Its later pieces then follow the normal per-piece rule.
- R8: A transaction whose source ID indexes a set bit of the mask (default 0x0F, so IDs 0 to 3) goes to the high queue, and all others go to the low queue. Bit 28 of the packet copies `req_wr`.
- R9: While the selected queue (depth 4) is full, issue stalls. No packet is lost, duplicated or reordered when the consumer holds its ready signal low.
- R10: `req_ready` is low from the cycle after a transaction is accepted until its last piece has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Splitter idle, transaction taken at this edge |
| req_addr | input | 16 | Start address in beats |
| req_len | input | 5 | Beat count minus one |
| req_src | input | 3 | Source ID, selects priority |
| req_wr | input | 1 | 1 for write, 0 for read |
| cred_ret | input | 1 | One response beat delivered, one credit back |
| hi_valid | output | 1 | High queue has a packet |
| hi_ready | input | 1 | Consumer takes high queue head |
| hi_pkt | output | 29 | High queue head {wr, seq, chan, len-1, addr} |
| lo_valid | output | 1 | Low queue has a packet |
| lo_ready | input | 1 | Consumer takes low queue head |
| lo_pkt | output | 29 | Low queue head, same layout |

## Verification
The bench aims at unaligned starts and runs that cross the channel wrap. Here a wrong cut would show up as a piece running over a block edge, or as a channel field taken from the transaction start instead of the piece start. It withholds credits to prove the stall point lands exactly at 24 reserved beats; a design that counted packets instead of beats, or ignored credits, would leak packets past that point. It returns credits slowly while a 32-beat transaction waits, so a design that skipped the empty-buffer wait would issue the first piece with beats still outstanding. It also drives more than 256 packets to expose a sequence wrap fault, and stalls the low queue to catch lost or doubled packets.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   typedef enum logic {
      PRIO_LO = 1'b0,
      PRIO_HI = 1'b1
   } prio_e;

   function automatic int min_int(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/ilv_fifo.sv
module ilv_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic         valid,
   output logic [W-1:0] dout
);
   localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNTW = $clog2(DEPTH + 1);

   logic [W-1:0]    mem [DEPTH];
   logic [PTRW-1:0] wp, rp;
   logic [CNTW-1:0] cnt;
   logic            do_pop;

   assign valid  = (cnt != '0);
   assign full   = (cnt == CNTW'(DEPTH));
   assign dout   = mem[rp];
   assign do_pop = pop && valid;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= (wp == PTRW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (do_pop) rp <= (rp == PTRW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         case ({push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt != CNTW'(DEPTH)));  // R9

endmodule

// File: rtl/ilv_credit.sv
module ilv_credit #(
   parameter int DEPTH = 24,
   parameter int TW    = 3,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] take,
   input  logic          ret,
   output logic [CW-1:0] avail,
   output logic          all_free
);
   logic [CW-1:0] cnt;

   assign avail    = cnt;
   assign all_free = (cnt == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= CW'(DEPTH);
      else        cnt <= cnt - CW'(take) + CW'(ret);
   end

   AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));  // R6
   AST_TAKE_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
      (take != '0) |-> (CW'(take) <= cnt));  // R6

endmodule

// File: rtl/ilv_cutter.sv
module ilv_cutter #(
   parameter int BLK  = 4,
   parameter int NCH  = 4,
   parameter int RW   = 6,
   localparam int OFFW = $clog2(BLK),
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int PBW  = $clog2(BLK + 1),
   localparam int SELW = OFFW + CHW
) (
   input  logic [SELW-1:0] addr_lo,
   input  logic [RW-1:0]   rem,
   output logic [PBW-1:0]  piece,
   output logic [CHW-1:0]  chan,
   output logic            last
);
   logic [PBW-1:0] room;

   assign room  = PBW'(BLK) - PBW'(addr_lo[OFFW-1:0]);
   assign piece = (rem < RW'(room)) ? PBW'(rem) : room;
   assign last  = (rem == RW'(piece));

   generate
      if (NCH > 1) begin : g_multi
         assign chan = addr_lo[OFFW +: CHW];
      end else begin : g_single
         assign chan = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ilv_splitter.sv
module ilv_splitter
   import ilv_pkg::*;
#(
   parameter int AW     = 16,
   parameter int LW     = 5,
   parameter int SRCW   = 3,
   parameter int BLK    = 4,
   parameter int NCH    = 4,
   parameter int SEQW   = 8,
   parameter int DEPTH  = 24,
   parameter int QDEPTH = 4,
   parameter logic [2**SRCW-1:0] HI_MASK = 'h0F,
   localparam int OFFW = $clog2(BLK),
   localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int PW   = 1 + SEQW + CHW + OFFW + AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [AW-1:0]   req_addr,
   input  logic [LW-1:0]   req_len,
   input  logic [SRCW-1:0] req_src,
   input  logic            req_wr,
   input  logic            cred_ret,
   output logic            hi_valid,
   input  logic            hi_ready,
   output logic [PW-1:0]   hi_pkt,
   output logic            lo_valid,
   input  logic            lo_ready,
   output logic [PW-1:0]   lo_pkt
);
   localparam int PBW  = $clog2(BLK + 1);
   localparam int RW   = LW + 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int SELW = OFFW + CHW;

   generate
      if (BLK < 2 || (BLK & (BLK - 1)) != 0) begin : g_bad_blk
         $error("block size must be a power of two of at least 2");
      end
      if (NCH < 1 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
         $error("channel count must be a power of two");
      end
      if (BLK > DEPTH) begin : g_bad_depth
         $error("reorder depth must hold at least one block");
      end
      if (AW < SELW) begin : g_bad_aw
         $error("address too narrow for block and channel fields");
      end
   endgenerate

   logic            busy_q, ovs_q, wr_q;
   prio_e           prio_q;
   logic [AW-1:0]   addr_q;
   logic [RW-1:0]   rem_q;
   logic [SEQW-1:0] seq_q;

   logic [PBW-1:0]  piece;
   logic [CHW-1:0]  chan;
   logic            last;
   logic [CW-1:0]   avail;
   logic            all_free;
   logic            credit_ok, issue, accept, sel_full;
   logic [RW-1:0]   beats_in;
   logic [PW-1:0]   pkt;
   logic [PBW-1:0]  take;
   logic [1:0]      q_full, q_valid, q_pop;
   logic [PW-1:0]   q_dout [2];

   ilv_cutter #(.BLK(BLK), .NCH(NCH), .RW(RW)) u_cut (
      .addr_lo (addr_q[SELW-1:0]),
      .rem     (rem_q),
      .piece   (piece),
      .chan    (chan),
      .last    (last)
   );

   ilv_credit #(.DEPTH(DEPTH), .TW(PBW)) u_cred (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .ret      (cred_ret),
      .avail    (avail),
      .all_free (all_free)
   );

   assign req_ready = !busy_q;
   assign accept    = req_valid && req_ready;
   assign beats_in  = RW'(req_len) + 1'b1;
   assign sel_full  = q_full[prio_q];
   assign credit_ok = ovs_q ? all_free : (avail >= CW'(piece));
   assign issue     = busy_q && !sel_full && credit_ok;
   assign take      = issue ? piece : '0;
   assign pkt       = {wr_q, seq_q, chan, OFFW'(piece - 1'b1), addr_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ovs_q  <= 1'b0;
         wr_q   <= 1'b0;
         prio_q <= PRIO_LO;
         addr_q <= '0;
         rem_q  <= '0;
         seq_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         ovs_q  <= (int'(beats_in) > DEPTH);
         wr_q   <= req_wr;
         prio_q <= HI_MASK[req_src] ? PRIO_HI : PRIO_LO;
         addr_q <= req_addr;
         rem_q  <= beats_in;
      end else if (issue) begin
         ovs_q  <= 1'b0;
         addr_q <= addr_q + AW'(piece);
         rem_q  <= rem_q - RW'(piece);
         seq_q  <= seq_q + 1'b1;
         if (last) busy_q <= 1'b0;
      end
   end

   assign q_pop = {hi_ready, lo_ready};

   for (genvar g = 0; g < 2; g++) begin : g_q
      ilv_fifo #(.W(PW), .DEPTH(QDEPTH)) u_q (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (issue && (prio_q == prio_e'(g))),
         .din   (pkt),
         .full  (q_full[g]),
         .pop   (q_pop[g]),
         .valid (q_valid[g]),
         .dout  (q_dout[g])
      );
   end

   assign hi_valid = q_valid[PRIO_HI];
   assign hi_pkt   = q_dout[PRIO_HI];
   assign lo_valid = q_valid[PRIO_LO];
   assign lo_pkt   = q_dout[PRIO_LO];

   AST_PIECE_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (piece != '0) &&
                (int'(addr_q[OFFW-1:0]) + int'(piece) <= BLK));  // R3
   AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && last) |=> req_ready);  // R10
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !issue) |=> ($stable(addr_q) && $stable(seq_q)));  // R9
   AST_OVS_ALL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && ovs_q) |-> (avail == CW'(DEPTH)));  // R7

endmodule

// File: tb/ilv_splitter_test.sv
module ilv_splitter_test;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 29;
   localparam int DEPTH = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [15:0] req_addr = '0;
   logic [4:0]  req_len = '0;
   logic [2:0]  req_src = '0;
   logic req_wr = 1'b0;
   logic cred_ret = 1'b0;
   logic hi_valid, lo_valid;
   logic hi_ready = 1'b1;
   logic lo_ready = 1'b1;
   logic [PW-1:0] hi_pkt, lo_pkt;

   int checks = 0;
   int fails  = 0;
   int seq_n  = 0;
   int popped = 0;
   int returned = 0;
   bit ret_en = 1'b1;
   bit ret_slow = 1'b0;
   int phase = 0;

   logic [PW-1:0] exp_q [2][$];
   bit            ovs_q [2][$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ilv_splitter uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_src(req_src), .req_wr(req_wr),
      .cred_ret(cred_ret),
      .hi_valid(hi_valid), .hi_ready(hi_ready), .hi_pkt(hi_pkt),
      .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_pkt(lo_pkt)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // reference: compare every transfer against the behavioural queues
   always @(negedge clk) begin
      if (rst_n) begin
         for (int q = 0; q < 2; q++) begin
            logic v, r;
            logic [PW-1:0] p, e;
            bit ov;
            v = (q == 1) ? hi_valid : lo_valid;
            r = (q == 1) ? hi_ready : lo_ready;
            p = (q == 1) ? hi_pkt : lo_pkt;
            if (v && r) begin
               if (exp_q[q].size() == 0) begin
                  check(1'b0, "R8", "packet on unexpected queue", q, 1 - q);
               end else begin
                  e  = exp_q[q].pop_front();
                  ov = ovs_q[q].pop_front();
                  check(p[19:18] == e[19:18], "R2", "channel", int'(p[19:18]), int'(e[19:18]));
                  check(p[15:0] == e[15:0], "R3", "piece address", int'(p[15:0]), int'(e[15:0]));
                  check(p[17:16] == e[17:16], "R3", "piece length", int'(p[17:16]), int'(e[17:16]));
                  check(p[27:20] == e[27:20], "R5", "sequence", int'(p[27:20]), int'(e[27:20]));
                  check(p[28] == e[28], "R8", "write flag", int'(p[28]), int'(e[28]));
                  if (ov) check(popped == returned, "R7", "outstanding at oversize start",
                                popped - returned, 0);
                  popped += int'(p[17:16]) + 1;
                  check(popped - returned <= DEPTH, "R6", "reserved beats",
                        popped - returned, DEPTH);
               end
            end
         end
         if (cred_ret) returned++;
      end
   end

   // credit return driver
   always begin
      @(posedge clk); #1;
      phase = (phase + 1) % 4;
      cred_ret = rst_n && ret_en && (popped > returned) && (!ret_slow || phase == 0);
   end

   task automatic send(input int addr, input int len, input int src, input bit wr);
      int a, rem, p;
      bit first;
      int q;
      q = (src < 4) ? 1 : 0;
      a = addr; rem = len + 1; first = 1'b1;
      while (rem > 0) begin
         p = 4 - (a % 4);
         if (rem < p) p = rem;
         exp_q[q].push_back({wr, 8'(seq_n), 2'((a / 4) % 4), 2'(p - 1), 16'(a)});
         ovs_q[q].push_back(first && (len + 1 > DEPTH));
         seq_n++; a += p; rem -= p; first = 1'b0;
      end
      while (!req_ready) begin @(posedge clk); #1; end
      req_valid = 1'b1; req_addr = 16'(addr); req_len = 5'(len);
      req_src = 3'(src); req_wr = wr;
      @(posedge clk); #1;
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R10", "ready after accept", int'(req_ready), 0);
   endtask

   task automatic drain();
      int n = 0;
      while ((exp_q[0].size() != 0 || exp_q[1].size() != 0 || popped != returned
              || !req_ready) && n < 2000) begin
         @(posedge clk); #1; n++;
      end
      check(exp_q[0].size() == 0 && exp_q[1].size() == 0, "R9", "packets left over",
            exp_q[0].size() + exp_q[1].size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog expired: actual hang expected completion");
      report();
      $finish;
   end

   initial begin
      int p0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(hi_valid == 1'b0, "R1", "hi_valid after reset", int'(hi_valid), 0);
      check(lo_valid == 1'b0, "R1", "lo_valid after reset", int'(lo_valid), 0);
      check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
      @(posedge clk); #1;

      // R4 R8 single-block transactions on both queues
      send(16'h0010, 0, 0, 1'b1);
      send(16'h0021, 0, 5, 1'b0);
      send(16'h0030, 3, 2, 1'b0);
      send(16'h0041, 1, 7, 1'b1);
      drain();

      // R3 R2 unaligned start across blocks, and channel wrap
      send(16'h0006, 6, 6, 1'b0);
      send(16'h000C, 15, 1, 1'b1);
      send(16'h0053, 13, 3, 1'b0);
      drain();

      // R5 sequence wrap past 256 packets
      for (int i = 0; i < 260; i++) send(16'(i * 4), 0, i % 8, i[0]);
      drain();

      // R9 low queue backpressure
      lo_ready = 1'b0;
      for (int i = 0; i < 3; i++) send(16'h0100 + 16'(i), 0, 4, 1'b0);
      send(16'h0200, 7, 6, 1'b1);
      repeat (10) begin @(posedge clk); #1; end
      check(req_ready == 1'b0, "R9", "stall while low queue full", int'(req_ready), 0);
      check(lo_valid == 1'b1, "R9", "low queue holding", int'(lo_valid), 1);
      lo_ready = 1'b1;
      send(16'h0300, 2, 0, 1'b0);
      drain();

      // R6 credit stall: 24 beats fit, the rest waits
      ret_en = 1'b0;
      p0 = popped;
      send(16'h0400, 15, 5, 1'b0);
      send(16'h0500, 15, 5, 1'b0);
      repeat (30) begin @(posedge clk); #1; end
      check(popped - p0 == DEPTH, "R6", "beats issued without credits", popped - p0, DEPTH);
      check(req_ready == 1'b0, "R6", "stalled on credits", int'(req_ready), 0);
      ret_en = 1'b1;
      drain();
      check(popped - p0 == 32, "R6", "beats after credits return", popped - p0, 32);

      // R7 oversize waits for an empty reorder buffer
      ret_slow = 1'b1;
      send(16'h0600, 11, 6, 1'b0);
      send(16'h0702, 31, 1, 1'b1);
      drain();
      send(16'h0800, 27, 4, 1'b0);
      drain();
      ret_slow = 1'b0;

      check(req_ready == 1'b1, "R10", "idle at end", int'(req_ready), 1);
      report();
      $finish;
   end

endmodule